// File: doc/BRIEF.md
# Control-Register Port Handshake Master

This block runs single accesses on the internal control-register port of a PHY. A local client gives it a 16-bit address, 16-bit data and a direction flag. The block then runs a short series of four-phase handshakes over a parallel command word and a response word.

In every handshake the block first shows a value with no strobe. It then raises one strobe and waits for the responder's ack to go high. Next it drops the strobe, keeps the value on the bus and waits for ack to go low. Each of the two waits has its own timeout.

A write is an address capture, then a data capture, then a write strobe. A read is an address capture, then a read strobe, and the returned data is latched while ack is high. The first handshake that fails ends the access and reports why. The ack input crosses a two-flop synchroniser, so the responder may sit in another clock domain. Only one access is in flight at a time.

Top module: `ctlport_hs_master`

## Requirements
- R1: Command word layout: bit 0 captures the address, bit 1 captures the data, bits 17:2 carry the presented value, bit 18 is the read strobe and bit 19 is the write strobe. The whole word is zero while the block is idle.
- R2: Response word layout: bit 0 is the ack and bits 16:1 are the returned data. The ack passes through two flip-flops before the sequencing logic uses it.
- R3: Every handshake takes three steps. First, one cycle with the value and no strobe. Second, the value with its strobe until the synchronised ack is high. Third, the value with no strobe until the synchronised ack is low.
- R4: A write runs three handshakes in this order: address capture with the address, data capture with the data, then the write strobe with the data still presented.
- R5: A read runs an address capture and then a read strobe with the address presented. The data field is sampled in the cycle the synchronised ack is first seen high in the read step. `rd_data` changes only when a read completes without error.
- R6: A strobe step that lasts TICK_CYCLES*POLL_STEPS cycles without the synchronised ack going high ends the access with error code 1. An ack seen in the last allowed cycle still counts as success.
- R7: A release step that lasts TICK_CYCLES*POLL_STEPS cycles without the synchronised ack going low ends the access with error code 2.
- R8: On a timeout the remaining handshakes are dropped. The command word returns to zero in the next cycle, and the responder sees no later capture or write strobe.
- R9: A request is taken only when `busy` is low. `busy` is high from the cycle after acceptance until completion. `req_valid` pulses while busy have no effect.
- R10: `done` is high for exactly one cycle, in the first cycle after completion, and `busy` is already low then. `err_code` (0 = success) is updated at that point and held until the next completion.
- R11: During reset, `busy`, `done`, `err_code`, `rd_data` and the command word are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request strobe, taken when `busy` is low |
| req_write | input | 1 | 1 = write access, 0 = read access |
| req_addr | input | 16 | Register address inside the PHY |
| req_data | input | 16 | Write data |
| busy | output | 1 | An access is in progress |
| cmd_word | output | 20 | Command word to the PHY port |
| rsp_word | input | 17 | Response word: ack and returned data |
| done | output | 1 | One-cycle completion pulse |
| err_code | output | 2 | 0 ok, 1 ack-high timeout, 2 ack-low timeout |
| rd_data | output | 16 | Data of the last successful read |

## Verification
An ack raised by the responder at one clock edge reaches the sequencer two edges later and changes the command word at the third edge. `done` and `err_code` show up one cycle after the final ack-low is seen, or after the wait counter reaches its limit. A behavioural model in the bench keeps its own two-stage ack history and wait count, driven by the same responder. The DUT outputs are compared against the model half a cycle after every edge, so each result is checked in exactly the cycle it falls due. Responder delays of 9 and 10 cycles place the ack on either side of the timeout limit.

// File: rtl/ctlport_pkg.sv
package ctlport_pkg;

  typedef enum logic [1:0] {
    HS_IDLE    = 2'd0,
    HS_SETUP   = 2'd1,
    HS_STROBE  = 2'd2,
    HS_RELEASE = 2'd3
  } hs_state_t;

  typedef enum logic [1:0] {
    PH_ADDR  = 2'd0,
    PH_DATA  = 2'd1,
    PH_WRITE = 2'd2,
    PH_READ  = 2'd3
  } hs_phase_t;

  localparam logic [1:0] ERR_NONE     = 2'd0;
  localparam logic [1:0] ERR_ACK_RISE = 2'd1;
  localparam logic [1:0] ERR_ACK_FALL = 2'd2;

endpackage

// File: rtl/ctlport_ack_sync.sv
module ctlport_ack_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d,
  output logic q
);

  logic [STAGES-1:0] chain_q;

  genvar i;
  generate
    for (i = 0; i < STAGES; i++) begin : g_stage
      if (i == 0) begin : g_first
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) chain_q[0] <= 1'b0;
          else        chain_q[0] <= d;
        end
      end else begin : g_next
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) chain_q[i] <= 1'b0;
          else        chain_q[i] <= chain_q[i-1];
        end
      end
    end
  endgenerate

  assign q = chain_q[STAGES-1];

endmodule

// File: rtl/ctlport_wait_timer.sv
module ctlport_wait_timer #(
  parameter int TICK_CYCLES = 200,
  parameter int POLL_STEPS  = 100
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  input  logic clr,
  output logic expire
);

  localparam int PW = (TICK_CYCLES > 1) ? $clog2(TICK_CYCLES) : 1;
  localparam int SW = (POLL_STEPS > 1) ? $clog2(POLL_STEPS) : 1;
  localparam logic [PW-1:0] PRE_LAST  = PW'(TICK_CYCLES - 1);
  localparam logic [SW-1:0] STEP_LAST = SW'(POLL_STEPS - 1);

  logic [PW-1:0] pre_q, pre_d;
  logic [SW-1:0] step_q, step_d;
  logic          tick_end;

  assign tick_end = (pre_q == PRE_LAST);
  assign expire   = run && tick_end && (step_q == STEP_LAST);

  always_comb begin
    pre_d  = pre_q;
    step_d = step_q;
    if (clr || !run) begin
      pre_d  = '0;
      step_d = '0;
    end else if (tick_end) begin
      pre_d  = '0;
      step_d = step_q + 1'b1;
    end else begin
      pre_d  = pre_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pre_q  <= '0;
      step_q <= '0;
    end else begin
      pre_q  <= pre_d;
      step_q <= step_d;
    end
  end

endmodule

// File: rtl/ctlport_cmd_enc.sv
module ctlport_cmd_enc
  import ctlport_pkg::*;
#(
  parameter int DW = 16
) (
  input  hs_state_t        st,
  input  hs_phase_t        ph,
  input  logic [DW-1:0]    val,
  output logic [DW+3:0]    cmd
);

  localparam int CAP_ADDR_BIT = 0;
  localparam int CAP_DATA_BIT = 1;
  localparam int READ_BIT     = DW + 2;
  localparam int WRITE_BIT    = DW + 3;

  always_comb begin
    cmd = '0;
    if (st != HS_IDLE) begin
      cmd[DW+1:2] = val;
    end
    if (st == HS_STROBE) begin
      unique case (ph)
        PH_ADDR:  cmd[CAP_ADDR_BIT] = 1'b1;
        PH_DATA:  cmd[CAP_DATA_BIT] = 1'b1;
        PH_READ:  cmd[READ_BIT]     = 1'b1;
        PH_WRITE: cmd[WRITE_BIT]    = 1'b1;
        default:  cmd[CAP_ADDR_BIT] = 1'b0;
      endcase
    end
  end

endmodule

// File: rtl/ctlport_hs_seq.sv
module ctlport_hs_seq
  import ctlport_pkg::*;
#(
  parameter int DW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req_valid,
  input  logic          req_write,
  input  logic [DW-1:0] req_addr,
  input  logic [DW-1:0] req_data,
  input  logic          ack_s,
  input  logic [DW-1:0] rsp_data,
  input  logic          tmo,
  output hs_state_t     st_q,
  output hs_phase_t     ph_q,
  output logic [DW-1:0] val_q,
  output logic          tmr_run,
  output logic          tmr_clr,
  output logic          busy,
  output logic          done,
  output logic [1:0]    err_code,
  output logic [DW-1:0] rd_data
);

  hs_state_t     st_d;
  hs_phase_t     ph_d;
  logic [DW-1:0] val_d;
  logic          wr_q;
  logic [DW-1:0] wdata_q;
  logic [DW-1:0] rdtmp_q;
  logic          done_d;
  logic [1:0]    err_d;
  logic          ld_req, ld_step, cap_rd, rd_en;

  // next-state logic
  always_comb begin
    st_d    = st_q;
    ph_d    = ph_q;
    val_d   = val_q;
    ld_req  = 1'b0;
    ld_step = 1'b0;
    cap_rd  = 1'b0;
    rd_en   = 1'b0;
    done_d  = 1'b0;
    err_d   = err_code;
    unique case (st_q)
      HS_IDLE: begin
        if (req_valid) begin
          st_d    = HS_SETUP;
          ph_d    = PH_ADDR;
          val_d   = req_addr;
          ld_req  = 1'b1;
          ld_step = 1'b1;
        end
      end
      HS_SETUP: begin
        st_d = HS_STROBE;
      end
      HS_STROBE: begin
        if (ack_s) begin
          st_d   = HS_RELEASE;
          cap_rd = (ph_q == PH_READ);
        end else if (tmo) begin
          st_d   = HS_IDLE;
          done_d = 1'b1;
          err_d  = ERR_ACK_RISE;
        end
      end
      HS_RELEASE: begin
        if (!ack_s) begin
          unique case (ph_q)
            PH_ADDR: begin
              st_d    = HS_SETUP;
              ld_step = 1'b1;
              if (wr_q) begin
                ph_d  = PH_DATA;
                val_d = wdata_q;
              end else begin
                ph_d  = PH_READ;
              end
            end
            PH_DATA: begin
              st_d    = HS_SETUP;
              ld_step = 1'b1;
              ph_d    = PH_WRITE;
            end
            default: begin
              st_d   = HS_IDLE;
              done_d = 1'b1;
              err_d  = ERR_NONE;
              rd_en  = (ph_q == PH_READ);
            end
          endcase
        end else if (tmo) begin
          st_d   = HS_IDLE;
          done_d = 1'b1;
          err_d  = ERR_ACK_FALL;
        end
      end
      default: st_d = HS_IDLE;
    endcase
  end

  assign tmr_run = (st_q == HS_STROBE) || (st_q == HS_RELEASE);
  assign tmr_clr = (st_d != st_q);
  assign busy    = (st_q != HS_IDLE);

  // registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q     <= HS_IDLE;
      ph_q     <= PH_ADDR;
      val_q    <= '0;
      wr_q     <= 1'b0;
      wdata_q  <= '0;
      rdtmp_q  <= '0;
      rd_data  <= '0;
      err_code <= ERR_NONE;
      done     <= 1'b0;
    end else begin
      st_q <= st_d;
      done <= done_d;
      if (ld_step) begin
        ph_q  <= ph_d;
        val_q <= val_d;
      end
      if (ld_req) begin
        wr_q    <= req_write;
        wdata_q <= req_data;
      end
      if (cap_rd) rdtmp_q  <= rsp_data;
      if (rd_en)  rd_data  <= rdtmp_q;
      if (done_d) err_code <= err_d;
    end
  end

endmodule

// File: rtl/ctlport_hs_master.sv
module ctlport_hs_master
  import ctlport_pkg::*;
#(
  parameter int DW          = 16,
  parameter int TICK_CYCLES = 200,
  parameter int POLL_STEPS  = 100,
  parameter int SYNC_STAGES = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req_valid,
  input  logic          req_write,
  input  logic [DW-1:0] req_addr,
  input  logic [DW-1:0] req_data,
  output logic          busy,
  output logic [DW+3:0] cmd_word,
  input  logic [DW:0]   rsp_word,
  output logic          done,
  output logic [1:0]    err_code,
  output logic [DW-1:0] rd_data
);

  logic          ack_s;
  logic          tmo;
  logic          tmr_run, tmr_clr;
  hs_state_t     st;
  hs_phase_t     ph;
  logic [DW-1:0] val;

  ctlport_ack_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .d     (rsp_word[0]),
    .q     (ack_s)
  );

  ctlport_wait_timer #(
    .TICK_CYCLES (TICK_CYCLES),
    .POLL_STEPS  (POLL_STEPS)
  ) u_timer (
    .clk    (clk),
    .rst_n  (rst_n),
    .run    (tmr_run),
    .clr    (tmr_clr),
    .expire (tmo)
  );

  ctlport_hs_seq #(.DW(DW)) u_seq (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_valid (req_valid),
    .req_write (req_write),
    .req_addr  (req_addr),
    .req_data  (req_data),
    .ack_s     (ack_s),
    .rsp_data  (rsp_word[DW:1]),
    .tmo       (tmo),
    .st_q      (st),
    .ph_q      (ph),
    .val_q     (val),
    .tmr_run   (tmr_run),
    .tmr_clr   (tmr_clr),
    .busy      (busy),
    .done      (done),
    .err_code  (err_code),
    .rd_data   (rd_data)
  );

  ctlport_cmd_enc #(.DW(DW)) u_enc (
    .st  (st),
    .ph  (ph),
    .val (val),
    .cmd (cmd_word)
  );

endmodule

// File: rtl/ctlport_hs_master_chk.sv
module ctlport_hs_master_chk #(
  parameter int DW = 16
) (
  input logic          clk,
  input logic          rst_n,
  input logic          req_valid,
  input logic          busy,
  input logic          done,
  input logic [DW+3:0] cmd_word,
  input logic [1:0]    err_code
);

  logic [3:0] strb;
  logic       any_strb;
  assign strb     = {cmd_word[DW+3], cmd_word[DW+2], cmd_word[1], cmd_word[0]};
  assign any_strb = |strb;

  // R1: idle means an all-zero command word
  p_idle_zero_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (cmd_word == '0));

  // R3: never more than one strobe at a time
  p_one_strobe_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(strb));

  // R3: a strobe rises only over a value already presented
  p_setup_first_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(any_strb) |-> ($past(cmd_word[DW+1:2]) == cmd_word[DW+1:2]));

  // R3: dropping the strobe inside an access keeps the value
  p_release_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(any_strb) && busy) |-> $stable(cmd_word[DW+1:2]));

  // R9: an accepted request makes the block busy
  p_accept_busy_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !busy) |=> busy);

  // R10: done is a single-cycle pulse, seen while not busy
  p_done_pulse_r10: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  p_done_idle_r10: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy);

  // R6 / R7: only defined error codes are reported
  p_err_legal_r6: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (err_code != 2'd3));

endmodule

bind ctlport_hs_master ctlport_hs_master_chk #(.DW(DW)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .req_valid (req_valid),
  .busy      (busy),
  .done      (done),
  .cmd_word  (cmd_word),
  .err_code  (err_code)
);

// File: tb/ctlport_hs_master_bench.sv
`timescale 1ns/1ps
module ctlport_hs_master_bench;

  localparam int DW    = 16;
  localparam int TICK  = 3;
  localparam int STEPS = 4;
  localparam int LIM   = TICK * STEPS;

  logic          clk;
  logic          rst_n;
  logic          req_valid, req_write;
  logic [15:0]   req_addr, req_data;
  logic          busy, done;
  logic [19:0]   cmd_word;
  logic [16:0]   rsp_word;
  logic [1:0]    err_code;
  logic [15:0]   rd_data;

  int tests = 0;
  int fails = 0;
  bit finished = 0;

  ctlport_hs_master #(.DW(DW), .TICK_CYCLES(TICK), .POLL_STEPS(STEPS)) u_ctlport_hs_master (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
    .req_addr(req_addr), .req_data(req_data), .busy(busy), .cmd_word(cmd_word),
    .rsp_word(rsp_word), .done(done), .err_code(err_code), .rd_data(rd_data));

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
    end
  endtask

  // ---------------- responder model ----------------
  int          rmode;   // 0 normal, 1 never raises ack, 2 never drops ack
  int          rdly;
  int          rcnt;
  logic        rsp_ack;
  logic [15:0] rsp_dout, r_addr, r_data;
  logic [15:0] rmem [0:255];
  logic        strobe_seen;

  assign strobe_seen = cmd_word[0] | cmd_word[1] | cmd_word[18] | cmd_word[19];
  assign rsp_word    = {rsp_dout, rsp_ack};

  always @(posedge clk) begin
    if (!rst_n) begin
      rsp_ack <= 1'b0; rsp_dout <= '0; r_addr <= '0; r_data <= '0; rcnt <= 0;
      for (int i = 0; i < 256; i++) rmem[i] <= '0;
    end else if (strobe_seen != rsp_ack) begin
      if ((strobe_seen && rmode == 1) || (!strobe_seen && rmode == 2)) rcnt <= 0;
      else if (rcnt + 1 >= rdly) begin
        rsp_ack <= strobe_seen;
        rcnt    <= 0;
        if (strobe_seen) begin
          if (cmd_word[0])  r_addr <= cmd_word[17:2];
          if (cmd_word[1])  r_data <= cmd_word[17:2];
          if (cmd_word[19]) rmem[r_addr[7:0]] <= r_data;
          if (cmd_word[18]) rsp_dout <= rmem[r_addr[7:0]];
        end
      end else rcnt <= rcnt + 1;
    end else rcnt <= 0;
  end

  // ---------------- behavioural reference ----------------
  int          m_st;          // 0 idle, 1 show value, 2 strobe, 3 release
  int          m_wait;
  bit          m_s1, m_s2, m_seen, m_is_rd, m_done;
  logic [1:0]  m_err;
  logic [15:0] m_rd, m_tmp;
  int          q_bit[$];
  logic [15:0] q_val[$];

  task automatic m_finish(input int code);
    m_st = 0; m_done = 1; m_err = 2'(code);
    if (code == 0 && m_is_rd) m_rd = m_tmp;
  endtask

  always @(posedge clk) begin
    if (!rst_n) begin
      m_st = 0; m_wait = 0; m_s1 = 0; m_s2 = 0; m_done = 0; m_err = 0; m_rd = 0; m_tmp = 0;
      q_bit.delete(); q_val.delete();
    end else begin
      m_seen = m_s2; m_s2 = m_s1; m_s1 = rsp_ack;
      m_done = 0;
      case (m_st)
        0: if (req_valid) begin
             q_bit.delete(); q_val.delete();
             q_bit.push_back(0); q_val.push_back(req_addr);
             if (req_write) begin
               q_bit.push_back(1);  q_val.push_back(req_data);
               q_bit.push_back(19); q_val.push_back(req_data);
             end else begin
               q_bit.push_back(18); q_val.push_back(req_addr);
             end
             m_is_rd = !req_write;
             m_st = 1;
           end
        1: begin m_st = 2; m_wait = 0; end
        2: if (m_seen) begin
             if (q_bit[0] == 18) m_tmp = rsp_dout;
             m_st = 3; m_wait = 0;
           end else if (m_wait == LIM - 1) m_finish(1);
           else m_wait++;
        3: if (!m_seen) begin
             void'(q_bit.pop_front()); void'(q_val.pop_front());
             if (q_bit.size() == 0) m_finish(0);
             else m_st = 1;
           end else if (m_wait == LIM - 1) m_finish(2);
           else m_wait++;
        default: m_st = 0;
      endcase
    end
  end

  function automatic logic [19:0] exp_cmd();
    logic [19:0] r;
    r = '0;
    if (m_st != 0) begin
      r[17:2] = q_val[0];
      if (m_st == 2) r[q_bit[0]] = 1'b1;
    end
    return r;
  endfunction

  // per-cycle comparison, half a cycle after each edge
  always @(negedge clk) begin
    if (rst_n && !finished) begin
      chk("R1 R2 R3 R4 R5 R8 cmd_word", 32'(cmd_word), 32'(exp_cmd()));
      chk("R9 busy", 32'(busy), 32'(m_st != 0));
      chk("R10 done", 32'(done), 32'(m_done));
      chk((m_err == 1) ? "R6 err_code" : (m_err == 2) ? "R7 err_code" : "R10 err_code",
          32'(err_code), 32'(m_err));
      chk("R5 rd_data", 32'(rd_data), 32'(m_rd));
    end
  end

  // ---------------- stimulus ----------------
  task automatic run_req(input bit wr, input logic [15:0] a, input logic [15:0] d,
                         input bit poke, output logic [1:0] e, output logic [15:0] rd);
    while (busy) @(negedge clk);
    req_valid = 1; req_write = wr; req_addr = a; req_data = d;
    @(negedge clk);
    req_valid = 0;
    if (poke) begin
      @(negedge clk); @(negedge clk);
      req_valid = 1; req_write = 1; req_addr = 16'h00EE; req_data = 16'hDEAD;
      @(negedge clk);
      req_valid = 0;
    end
    while (!done) @(negedge clk);
    e = err_code; rd = rd_data;
    @(negedge clk);
    if (poke) chk("R9 no second access after poke", 32'(busy), 32'd0);
    repeat (30) @(negedge clk);
  endtask

  initial begin
    logic [1:0]  e;
    logic [15:0] rd;
    rmode = 0; rdly = 1;
    req_valid = 0; req_write = 0; req_addr = 0; req_data = 0;
    rst_n = 0;
    repeat (4) @(negedge clk);
    // R11 reset state
    chk("R11 busy", 32'(busy), 0);
    chk("R11 done", 32'(done), 0);
    chk("R11 err_code", 32'(err_code), 0);
    chk("R11 rd_data", 32'(rd_data), 0);
    chk("R11 cmd_word", 32'(cmd_word), 0);
    rst_n = 1;
    repeat (3) @(negedge clk);

    // R4 / R5: write then read back, fast responder
    run_req(1, 16'h0010, 16'h1234, 0, e, rd);
    chk("R4 write ok", 32'(e), 0);
    run_req(0, 16'h0010, 16'h0000, 0, e, rd);
    chk("R5 read data", 32'(rd), 32'h1234);
    // R9: a pulse while busy is ignored
    run_req(1, 16'h0020, 16'hA5A5, 1, e, rd);
    run_req(0, 16'h0020, 16'h0000, 0, e, rd);
    chk("R4 read back", 32'(rd), 32'hA5A5);
    run_req(0, 16'h00EE, 16'h0000, 0, e, rd);
    chk("R9 poked address untouched", 32'(rd), 32'h0000);
    run_req(0, 16'h0020, 16'h0000, 0, e, rd);

    // R6 / R5: ack never rises on a read, rd_data keeps last good value
    rmode = 1;
    run_req(0, 16'h0010, 16'h0000, 0, e, rd);
    chk("R6 ack-high timeout code", 32'(e), 1);
    chk("R5 rd_data held after failed read", 32'(rd), 32'hA5A5);
    rmode = 0;

    // slower responder
    rdly = 3;
    run_req(1, 16'h007F, 16'hFFFF, 0, e, rd);
    run_req(0, 16'h007F, 16'h0000, 0, e, rd);
    chk("R5 read slow responder", 32'(rd), 32'hFFFF);

    // R6 boundary: delay 9 -> ack seen in last allowed cycle, delay 10 -> timeout
    rdly = 9;
    run_req(1, 16'h0005, 16'h0F0F, 0, e, rd);
    chk("R6 last-cycle ack succeeds", 32'(e), 0);
    rdly = 10;
    run_req(1, 16'h0006, 16'h1111, 0, e, rd);
    chk("R6 one cycle late times out", 32'(e), 1);
    rdly = 1;
    run_req(0, 16'h0006, 16'h0000, 0, e, rd);
    chk("R8 aborted write left no data", 32'(rd), 32'h0000);
    run_req(0, 16'h0005, 16'h0000, 0, e, rd);
    chk("R6 boundary write landed", 32'(rd), 32'h0F0F);

    // R7 / R8: ack never drops after address capture
    rmode = 2; rdly = 2;
    run_req(1, 16'h0033, 16'hBEEF, 0, e, rd);
    chk("R7 ack-low timeout code", 32'(e), 2);
    rmode = 0; rdly = 1;
    repeat (20) @(negedge clk);
    run_req(0, 16'h0033, 16'h0000, 0, e, rd);
    chk("R8 remaining steps dropped", 32'(rd), 32'h0000);
    chk("R10 success clears code", 32'(e), 0);

    finished = 1;
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    #200000;
    if (!finished) begin
      fails++;
      $display("FAIL R9 watchdog: actual=hung expected=done");
      finished = 1;
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

endmodule